// File: doc/BRIEF.md
# Asynchronous Static Memory Access Controller

This block turns single word requests from an on-chip master into timed read and write cycles on an external asynchronous memory such as SRAM, NOR flash or a memory-mapped peripheral. Each access runs in order through a setup phase, a strobe phase and a hold phase. The length of each phase is set separately for reads and for writes. After every access the block inserts a turnaround gap. During the gap no chip select or strobe is active and the data bus is not driven.

The memory can stretch the strobe phase by driving an active-low wait input. Two flops synchronize this input. A wait that the controller sees late is ignored. A wait that never ends is cut off after a programmable maximum count. The access is then still completed, but it is acknowledged with an error and a sticky timeout flag is raised.

On the internal side the master holds `req` high together with the access fields until it sees the one-cycle `ack` pulse. It must lower `req` in that same cycle unless it presents the next access at once. In the last turnaround cycle a high `req` starts a new access without passing through idle. The timing fields must stay stable while an access is in flight.

Top module: `xmem_async_ctrl`

## Requirements
- R1: After reset both chip selects, the output enable and the write enable are high (inactive), the data bus is not driven, and `ack`, `ack_err` and `timeout_flag` are low.
- R2: The setup phase lasts `cfg_rd_setup+1` cycles for a read and `cfg_wr_setup+1` cycles for a write (1 to 16). During setup the selected chip select is low and both strobes are high.
- R3: The nominal strobe phase lasts `cfg_rd_strobe+1` or `cfg_wr_strobe+1` cycles (1 to 64). During strobe only `mem_oe_n` is low for a read, and only `mem_we_n` is low for a write.
- R4: The hold phase lasts `cfg_rd_hold+1` or `cfg_wr_hold+1` cycles (1 to 8). The chip select stays low and both strobes are high.
- R5: `ack` is high for exactly one cycle, the first cycle after hold. With back-to-back requests the chip selects stay high for exactly `cfg_turn+1` cycles (1 to 4) between the end of one hold phase and the next setup phase.
- R6: `req_cs`=0 drives `mem_cs_n[0]` low and `req_cs`=1 drives `mem_cs_n[1]` low. At most one chip select is low. `mem_addr` and `mem_ba` carry the request fields for the whole access.
- R7: For a read, `rdata` takes the value of `mem_dq_in` at the clock edge that ends strobe, when `mem_oe_n` rises. It holds that value until the next read.
- R8: For a write, `mem_dq_oe` is high and `mem_dq_out` equals the write data from the first setup cycle to the last hold cycle. `mem_dq_oe` is low during reads, turnaround and idle.
- R9: If the synchronized wait is seen low in a strobe cycle with at least 4 nominal strobe cycles still remaining (counting that cycle), the strobe is extended past its nominal end until the wait is seen high, by at least one cycle. A wait driven low from the start and released at the negedge of strobe cycle n gives a strobe of max(n+2, S+1) cycles, where S is the nominal length.
- R10: A wait first seen low with fewer than 4 nominal strobe cycles remaining is ignored. It is always ignored for nominal strobes shorter than 4 cycles. The strobe then keeps its nominal length and `ack_err` stays low.
- R11: The extension lasts at most `cfg_max_wait+1` cycles (1 to 256). If the wait is still low at that point, the controller runs the hold phase and acknowledges the access with `ack_err` high.
- R12: `timeout_flag` goes high with the `ack` of a timed-out access and stays high through later accesses until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, held until ack |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 1 | Chip select choice (0 or 1) |
| req_addr | input | 22 | Word address |
| req_bank | input | 2 | Bank address |
| req_wdata | input | 16 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| ack_err | output | 1 | Completion was a wait timeout |
| rdata | output | 16 | Captured read data |
| timeout_flag | output | 1 | Sticky timeout status |
| cfg_rd_setup | input | 4 | Read setup length minus one |
| cfg_rd_strobe | input | 6 | Read strobe length minus one |
| cfg_rd_hold | input | 3 | Read hold length minus one |
| cfg_wr_setup | input | 4 | Write setup length minus one |
| cfg_wr_strobe | input | 6 | Write strobe length minus one |
| cfg_wr_hold | input | 3 | Write hold length minus one |
| cfg_turn | input | 2 | Turnaround length minus one |
| cfg_max_wait | input | 8 | Maximum wait extension minus one |
| mem_cs_n | output | 2 | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_addr | output | 22 | Memory address |
| mem_ba | output | 2 | Memory bank address |
| mem_dq_out | output | 16 | Data driven to memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 16 | Data returned by memory |
| mem_wait_n | input | 1 | Active-low wait from memory |

## Verification
The hardest point to reach is the edge of the 4-cycle wait window. The two synchronizer flops delay the wait by a fixed amount, so the bench must know in which strobe cycle the state machine first sees a change on the pin. The bench therefore drives the wait pin at the negedge of a counted strobe cycle. It pairs a wait asserted at strobe cycle 5 of a 10-cycle strobe (honoured) with one asserted at cycle 6 (ignored), and it tests nominal strobes of 3 and 4 cycles against a wait held low from the start. Waits that are never released, including the full 256-cycle limit, reach the timeout path, and random accesses with waits released at various cycles cover the extension formula.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_TURN   = 3'd4
    } phase_e;

endpackage

// File: rtl/xmem_wait_sync.sv
module xmem_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_n_async,
    output logic wait_seen
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], wait_n_async};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign wait_seen = ~sync_q[STAGES-1];
endmodule

// File: rtl/xmem_phase_sel.sv
module xmem_phase_sel
    import xmem_pkg::*;
#(
    parameter int SETUP_W  = 4,
    parameter int STROBE_W = 6,
    parameter int HOLD_W   = 3,
    parameter int TURN_W   = 2,
    parameter int CNT_W    = 6
) (
    input  logic                is_write,
    input  phase_e              target,
    input  logic [SETUP_W-1:0]  rd_setup,
    input  logic [STROBE_W-1:0] rd_strobe,
    input  logic [HOLD_W-1:0]   rd_hold,
    input  logic [SETUP_W-1:0]  wr_setup,
    input  logic [STROBE_W-1:0] wr_strobe,
    input  logic [HOLD_W-1:0]   wr_hold,
    input  logic [TURN_W-1:0]   turn,
    output logic [CNT_W-1:0]    len_m1
);
    always_comb begin
        unique case (target)
            PH_SETUP:  len_m1 = is_write ? CNT_W'(wr_setup)  : CNT_W'(rd_setup);
            PH_STROBE: len_m1 = is_write ? CNT_W'(wr_strobe) : CNT_W'(rd_strobe);
            PH_HOLD:   len_m1 = is_write ? CNT_W'(wr_hold)   : CNT_W'(rd_hold);
            PH_TURN:   len_m1 = CNT_W'(turn);
            default:   len_m1 = '0;
        endcase
    end
endmodule

// File: rtl/xmem_async_ctrl.sv
module xmem_async_ctrl
    import xmem_pkg::*;
#(
    parameter int ADDR_W      = 22,
    parameter int BANK_W      = 2,
    parameter int DATA_W      = 16,
    parameter int NUM_CS      = 2,
    parameter int SETUP_W     = 4,
    parameter int STROBE_W    = 6,
    parameter int HOLD_W      = 3,
    parameter int TURN_W      = 2,
    parameter int MAXW_W      = 8,
    parameter int WAIT_WINDOW = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req,
    input  logic                      req_write,
    input  logic [$clog2(NUM_CS)-1:0] req_cs,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [BANK_W-1:0]         req_bank,
    input  logic [DATA_W-1:0]         req_wdata,
    output logic                      ack,
    output logic                      ack_err,
    output logic [DATA_W-1:0]         rdata,
    output logic                      timeout_flag,
    input  logic [SETUP_W-1:0]        cfg_rd_setup,
    input  logic [STROBE_W-1:0]       cfg_rd_strobe,
    input  logic [HOLD_W-1:0]         cfg_rd_hold,
    input  logic [SETUP_W-1:0]        cfg_wr_setup,
    input  logic [STROBE_W-1:0]       cfg_wr_strobe,
    input  logic [HOLD_W-1:0]         cfg_wr_hold,
    input  logic [TURN_W-1:0]         cfg_turn,
    input  logic [MAXW_W-1:0]         cfg_max_wait,
    output logic [NUM_CS-1:0]         mem_cs_n,
    output logic                      mem_oe_n,
    output logic                      mem_we_n,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [BANK_W-1:0]         mem_ba,
    output logic [DATA_W-1:0]         mem_dq_out,
    output logic                      mem_dq_oe,
    input  logic [DATA_W-1:0]         mem_dq_in,
    input  logic                      mem_wait_n
);
    localparam int CS_W  = $clog2(NUM_CS);
    localparam int MAX_A = (SETUP_W > STROBE_W) ? SETUP_W : STROBE_W;
    localparam int MAX_B = (HOLD_W > TURN_W) ? HOLD_W : TURN_W;
    localparam int CNT_W = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam logic [CNT_W-1:0] WIN_CNT = CNT_W'(WAIT_WINDOW - 1);

    typedef struct packed {
        phase_e              ph;
        logic [CNT_W-1:0]    cnt;
        logic                ext;
        logic                armed;
        logic [MAXW_W-1:0]   wcnt;
        logic                tmo;
        logic                wr;
        logic [CS_W-1:0]     cs;
        logic [ADDR_W-1:0]   addr;
        logic [BANK_W-1:0]   bank;
        logic [DATA_W-1:0]   wdata;
        logic [DATA_W-1:0]   rdata;
        logic                ack;
        logic                err;
        logic                flag;
    } ctrl_t;

    ctrl_t            ctl_d, ctl_q;
    logic             wait_seen;
    phase_e           tgt_ph;
    logic             tgt_wr;
    logic [CNT_W-1:0] tgt_len;
    logic             launch;
    logic             to_hold;
    logic             in_access;

    xmem_wait_sync #(.STAGES(SYNC_STAGES)) u_wsync (
        .clk          (clk),
        .rst_n        (rst_n),
        .wait_n_async (mem_wait_n),
        .wait_seen    (wait_seen)
    );

    always_comb begin
        unique case (ctl_q.ph)
            PH_SETUP:  tgt_ph = PH_STROBE;
            PH_STROBE: tgt_ph = PH_HOLD;
            PH_HOLD:   tgt_ph = PH_TURN;
            default:   tgt_ph = PH_SETUP;
        endcase
        tgt_wr = (ctl_q.ph == PH_IDLE || ctl_q.ph == PH_TURN) ? req_write : ctl_q.wr;
    end

    xmem_phase_sel #(
        .SETUP_W(SETUP_W), .STROBE_W(STROBE_W), .HOLD_W(HOLD_W),
        .TURN_W(TURN_W), .CNT_W(CNT_W)
    ) u_len (
        .is_write  (tgt_wr),
        .target    (tgt_ph),
        .rd_setup  (cfg_rd_setup),
        .rd_strobe (cfg_rd_strobe),
        .rd_hold   (cfg_rd_hold),
        .wr_setup  (cfg_wr_setup),
        .wr_strobe (cfg_wr_strobe),
        .wr_hold   (cfg_wr_hold),
        .turn      (cfg_turn),
        .len_m1    (tgt_len)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.ack = 1'b0;
        ctl_d.err = 1'b0;
        launch    = 1'b0;
        to_hold   = 1'b0;
        unique case (ctl_q.ph)
            PH_IDLE: launch = req;
            PH_SETUP: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.ph    = PH_STROBE;
                    ctl_d.cnt   = tgt_len;
                    ctl_d.ext   = 1'b0;
                    ctl_d.armed = 1'b0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                if (!ctl_q.ext) begin
                    // window: only waits seen early enough may stretch the strobe
                    if (wait_seen && ctl_q.cnt >= WIN_CNT) ctl_d.armed = 1'b1;
                    if (ctl_q.cnt == '0) begin
                        if (ctl_q.armed) begin
                            ctl_d.ext  = 1'b1;
                            ctl_d.wcnt = cfg_max_wait;
                        end else begin
                            to_hold = 1'b1;
                        end
                    end else begin
                        ctl_d.cnt = ctl_q.cnt - 1'b1;
                    end
                end else if (!wait_seen) begin
                    to_hold = 1'b1;
                end else if (ctl_q.wcnt == '0) begin
                    to_hold   = 1'b1;
                    ctl_d.tmo = 1'b1;
                end else begin
                    ctl_d.wcnt = ctl_q.wcnt - 1'b1;
                end
                if (to_hold) begin
                    ctl_d.ph  = PH_HOLD;
                    ctl_d.cnt = tgt_len;
                    ctl_d.ext = 1'b0;
                    if (!ctl_q.wr) ctl_d.rdata = mem_dq_in;
                end
            end
            PH_HOLD: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.ph   = PH_TURN;
                    ctl_d.cnt  = tgt_len;
                    ctl_d.ack  = 1'b1;
                    ctl_d.err  = ctl_q.tmo;
                    ctl_d.flag = ctl_q.flag | ctl_q.tmo;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            PH_TURN: begin
                if (ctl_q.cnt == '0) begin
                    launch = req;
                    if (!req) ctl_d.ph = PH_IDLE;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            default: ctl_d.ph = PH_IDLE;
        endcase
        if (launch) begin
            ctl_d.ph    = PH_SETUP;
            ctl_d.cnt   = tgt_len;
            ctl_d.wr    = req_write;
            ctl_d.cs    = req_cs;
            ctl_d.addr  = req_addr;
            ctl_d.bank  = req_bank;
            ctl_d.wdata = req_wdata;
            ctl_d.tmo   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign in_access = (ctl_q.ph == PH_SETUP) || (ctl_q.ph == PH_STROBE) || (ctl_q.ph == PH_HOLD);

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign mem_cs_n[i] = !(in_access && (ctl_q.cs == CS_W'(i)));
    end

    assign mem_oe_n     = !(ctl_q.ph == PH_STROBE && !ctl_q.wr);
    assign mem_we_n     = !(ctl_q.ph == PH_STROBE && ctl_q.wr);
    assign mem_addr     = ctl_q.addr;
    assign mem_ba       = ctl_q.bank;
    assign mem_dq_out   = ctl_q.wdata;
    assign mem_dq_oe    = in_access && ctl_q.wr;
    assign ack          = ctl_q.ack;
    assign ack_err      = ctl_q.err;
    assign rdata        = ctl_q.rdata;
    assign timeout_flag = ctl_q.flag;

    assert_ack_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    assert_cs_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));
    assert_capture_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ph == PH_HOLD && $past(ctl_q.ph) == PH_STROBE && !ctl_q.wr)
        |-> (rdata == $past(mem_dq_in)));
    assert_no_drive_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n));
    assert_err_with_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ack_err |-> ack);
    assert_flag_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_flag |=> timeout_flag);
endmodule

// File: tb/sim_xmem_async_ctrl.sv
`timescale 1ns/1ps
module sim_xmem_async_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_write = 1'b0;
    logic [0:0]  req_cs = 1'b0;
    logic [21:0] req_addr = '0;
    logic [1:0]  req_bank = '0;
    logic [15:0] req_wdata = '0;
    logic [3:0]  cfg_rd_setup = '0, cfg_wr_setup = '0;
    logic [5:0]  cfg_rd_strobe = '0, cfg_wr_strobe = '0;
    logic [2:0]  cfg_rd_hold = '0, cfg_wr_hold = '0;
    logic [1:0]  cfg_turn = '0;
    logic [7:0]  cfg_max_wait = '0;
    logic        mem_wait_n = 1'b1;
    wire         ack, ack_err, timeout_flag, mem_oe_n, mem_we_n, mem_dq_oe;
    wire [15:0]  rdata, mem_dq_out, mem_dq_in;
    wire [1:0]   mem_cs_n, mem_ba;
    wire [21:0]  mem_addr;

    int n_checks = 0;
    int n_err = 0;
    int prev_turn = 1;
    bit sticky = 0;

    always #10 clk = ~clk;

    // memory model: pattern derived from address, junk while output enable is high
    assign mem_dq_in = mem_oe_n ? 16'hDEAD : (mem_addr[15:0] ^ 16'h5A3C);

    xmem_async_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write), .req_cs(req_cs),
        .req_addr(req_addr), .req_bank(req_bank), .req_wdata(req_wdata),
        .ack(ack), .ack_err(ack_err), .rdata(rdata), .timeout_flag(timeout_flag),
        .cfg_rd_setup(cfg_rd_setup), .cfg_rd_strobe(cfg_rd_strobe), .cfg_rd_hold(cfg_rd_hold),
        .cfg_wr_setup(cfg_wr_setup), .cfg_wr_strobe(cfg_wr_strobe), .cfg_wr_hold(cfg_wr_hold),
        .cfg_turn(cfg_turn), .cfg_max_wait(cfg_max_wait),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_ba(mem_ba), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in), .mem_wait_n(mem_wait_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // mode 0: no wait; 1: low from start, released at strobe cycle n; 2: driven low at strobe cycle n
    function automatic int exp_strobe(input int st, input int mw, input int mode,
                                      input int n, output bit tmo);
        int len;
        tmo = 0;
        if (mode == 0) return st;
        if (mode == 1) begin
            if (st < 4) return st;
            len = (n + 2 > st + 1) ? n + 2 : st + 1;
            if (len > st + mw) begin
                tmo = 1;
                return st + mw;
            end
            return len;
        end
        if (st - (n + 2) >= 3) begin
            tmo = 1;
            return st + mw;
        end
        return st;
    endfunction

    task automatic run_access(input bit wr, input bit sel, input logic [21:0] a,
                              input logic [1:0] b, input logic [15:0] d,
                              input int mode, input int wn, input bit chain, input bit keep);
        int st, mw, se, su_e, ho_e, gap_e;
        int su, sb, ho, gap, cyc;
        bit tmo_e, got, bad_bus, bad_pin, bad_dq;
        logic [15:0] rd;
        logic er;
        string wtag;
        if (!chain) repeat (6) @(negedge clk);
        gap_e = prev_turn - 1;
        st   = wr ? cfg_wr_strobe + 1 : cfg_rd_strobe + 1;
        su_e = wr ? cfg_wr_setup + 1 : cfg_rd_setup + 1;
        ho_e = wr ? cfg_wr_hold + 1 : cfg_rd_hold + 1;
        mw   = cfg_max_wait + 1;
        se   = exp_strobe(st, mw, mode, wn, tmo_e);
        req = 1'b1; req_write = wr; req_cs = sel; req_addr = a; req_bank = b; req_wdata = d;
        if (mode == 1) mem_wait_n = 1'b0;
        su = 0; sb = 0; ho = 0; gap = 0; cyc = 0;
        got = 0; bad_bus = 0; bad_pin = 0; bad_dq = 0; rd = '0; er = 1'b0;
        while (!got && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (mem_cs_n == 2'b11) begin
                if (!mem_oe_n || !mem_we_n || mem_dq_oe) bad_dq = 1;
                if (ack) begin
                    got = 1; rd = rdata; er = ack_err;
                end else if (su == 0) begin
                    gap++;
                end
            end else begin
                if (mem_cs_n != (sel ? 2'b01 : 2'b10) || mem_addr != a || mem_ba != b) bad_bus = 1;
                if (mem_dq_oe != wr || (wr && mem_dq_out != d)) bad_dq = 1;
                if (!mem_oe_n || !mem_we_n) begin
                    sb++;
                    if ((wr && mem_we_n) || (!wr && mem_oe_n) || (!mem_oe_n && !mem_we_n)) bad_pin = 1;
                    if (mode == 1 && sb == wn) mem_wait_n = 1'b1;
                    if (mode == 2 && sb == wn) mem_wait_n = 1'b0;
                end else if (sb == 0) begin
                    su++;
                end else begin
                    ho++;
                end
            end
        end
        if (!keep) req = 1'b0;
        mem_wait_n = 1'b1;
        prev_turn = cfg_turn + 1;
        sticky = sticky | tmo_e;
        wtag = (mode == 0) ? "R3" : (tmo_e ? "R11" : (se > st ? "R9" : "R10"));
        chk(got, "R5 ack seen", int'(got), 1);
        chk(su == su_e, "R2 setup length", su, su_e);
        chk(sb == se, {wtag, " strobe length"}, sb, se);
        chk(!bad_pin, "R3 strobe pin", int'(bad_pin), 0);
        chk(ho == ho_e, "R4 hold length", ho, ho_e);
        if (chain) chk(gap == gap_e, "R5 turnaround gap", gap, gap_e);
        chk(!bad_bus, "R6 select/address/bank", int'(bad_bus), 0);
        chk(!bad_dq, "R8 data drive", int'(bad_dq), 0);
        if (!wr) chk(rd == (a[15:0] ^ 16'h5A3C), "R7 read data", int'(rd), int'(a[15:0] ^ 16'h5A3C));
        chk(er == tmo_e, {(tmo_e ? "R11" : wtag), " ack_err"}, int'(er), int'(tmo_e));
        chk(timeout_flag == sticky, "R12 timeout flag", int'(timeout_flag), int'(sticky));
    endtask

    task automatic set_cfg(input int rs, input int rst, input int rh, input int ws,
                           input int wst, input int wh, input int t, input int mw);
        cfg_rd_setup = 4'(rs); cfg_rd_strobe = 6'(rst); cfg_rd_hold = 3'(rh);
        cfg_wr_setup = 4'(ws); cfg_wr_strobe = 6'(wst); cfg_wr_hold = 3'(wh);
        cfg_turn = 2'(t); cfg_max_wait = 8'(mw);
    endtask

    task automatic check_reset(input string tag);
        chk(mem_cs_n == 2'b11 && mem_oe_n && mem_we_n && !mem_dq_oe, {tag, " strobes idle"},
            int'({mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe}), 5'b11110);
        chk(!ack && !ack_err && !timeout_flag, {tag, " status low"},
            int'({ack, ack_err, timeout_flag}), 0);
    endtask

    initial begin
        #(200000 * 20);
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        bit keep_prev;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check_reset("R1");
        rst_n = 1'b1;
        @(negedge clk);

        // R10: 3-cycle strobe cannot be stretched
        set_cfg(1, 2, 1, 1, 2, 1, 1, 3);
        run_access(0, 0, 22'h00_1234, 2'd1, 16'h0, 1, 100000, 0, 0);
        // R9/R11: 4-cycle strobe honoured, wait never released
        set_cfg(1, 3, 1, 1, 3, 1, 1, 2);
        run_access(0, 1, 22'h2A_5555, 2'd2, 16'h0, 1, 100000, 0, 0);
        // late wait at strobe cycle 5 of 10: honoured, then times out
        set_cfg(0, 9, 0, 2, 9, 2, 0, 1);
        run_access(1, 0, 22'h11_0F0F, 2'd3, 16'hA5A5, 2, 5, 0, 0);
        // cycle 6 of 10: one cycle too late, ignored
        run_access(1, 1, 22'h01_F00F, 2'd0, 16'h5A5A, 2, 6, 0, 0);
        // R9: release inside extension
        set_cfg(2, 7, 3, 2, 7, 3, 2, 19);
        run_access(0, 0, 22'h3F_FFFF, 2'd3, 16'h0, 1, 12, 0, 0);
        // R9: early release still adds one cycle
        run_access(0, 1, 22'h00_0001, 2'd1, 16'h0, 1, 1, 0, 0);
        // R11: full 256-cycle limit
        set_cfg(0, 4, 0, 0, 4, 0, 3, 255);
        run_access(1, 0, 22'h15_AAAA, 2'd2, 16'hFFFF, 1, 100000, 0, 0);

        // R12 cleared only by reset; R1 after reset
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset("R1 after reset");
        sticky = 0;
        rst_n = 1'b1;

        // boundary lengths, back to back (R5 gaps)
        set_cfg(0, 0, 0, 0, 0, 0, 0, 0);
        run_access(1, 0, 22'h00_0100, 2'd0, 16'h1357, 0, 0, 0, 1);
        run_access(0, 0, 22'h00_0200, 2'd1, 16'h0, 0, 0, 1, 1);
        set_cfg(15, 63, 7, 15, 63, 7, 3, 0);
        run_access(1, 1, 22'h00_0300, 2'd2, 16'h2468, 0, 0, 1, 1);
        run_access(0, 1, 22'h00_0400, 2'd3, 16'h0, 0, 0, 1, 0);

        // random mix
        keep_prev = 0;
        for (int i = 0; i < 80; i++) begin
            bit wr, sel, kp;
            int mode, wn;
            set_cfg($urandom_range(0, 15), $urandom_range(0, 20), $urandom_range(0, 7),
                    $urandom_range(0, 15), $urandom_range(0, 20), $urandom_range(0, 7),
                    $urandom_range(0, 3), $urandom_range(0, 15));
            wr   = 1'($urandom_range(0, 1));
            sel  = 1'($urandom_range(0, 1));
            kp   = 1'($urandom_range(0, 1));
            mode = ($urandom_range(0, 3) == 0) ? 1 : 0;
            wn   = $urandom_range(1, 24);
            run_access(wr, sel, 22'($urandom), 2'($urandom), 16'($urandom),
                       mode, wn, keep_prev, kp);
            keep_prev = kp;
        end
        req = 1'b0;
        repeat (8) @(negedge clk);
        chk(mem_cs_n == 2'b11 && !mem_dq_oe, "R8 idle after run", int'(mem_cs_n), 3);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule